// File: doc/BRIEF.md
# Three-Wire Serial Latch Loader

This block is the programming front end of a frequency synthesizer. A host drives three slow lines: a serial clock, a data line and a load strobe. The block samples all three into the fast system clock domain through two-flop synchronizers and reacts only to detected edges. Every rising edge of the serial clock, taken while the load strobe is low, shifts one data bit into a word register, most significant bit first.

When the load strobe rises, the two trailing bits of the word pick a destination, and that destination takes the word. Four destinations exist: a reference divider value, a pair of main counter values, a function word and an initialization word. Writing the initialization word also writes the function word with the same payload. Each destination raises a one-cycle strobe in the cycle its contents change, so downstream counters can reload.

Top module: `serial_latch_loader`

## Requirements
- R1: After synchronous reset, every latch output is zero and every update strobe is low.
- R2: Each rising edge of the synchronized serial clock, seen while the synchronized load line is low, shifts the synchronized data bit into the word register at bit 0. Earlier bits move toward the most significant end, so the first bit sent lands in bit WORD_W-1 after WORD_W edges.
- R3: A rising edge of the synchronized load line transfers the word to the latch chosen by bits [1:0]: 00 goes to the reference latch, 01 to the counter latch, 10 to the function latch, 11 to the initialization latch.
- R4: The reference latch output equals word bits [15:2], which is the 14-bit reference divide value.
- R5: The counter latch gives the A value from word bits [6:2] (5 bits) and the B value from word bits [19:7] (13 bits).
- R6: The function latch and the initialization latch each store word bits [20:2] (19 bits).
- R7: Control code 11 writes the same 19-bit payload into both the initialization latch and the function latch.
- R8: Each latch raises its update strobe for exactly one system clock cycle, in the same cycle its new value first appears. Code 11 raises both the initialization and the function strobes. No strobe rises without a load.
- R9: Serial clock rising edges that occur while the load line is high do not shift. A word loaded after such edges still holds the bits sent before the load.
- R10: Latches that are not addressed keep their values across a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Asynchronous serial clock |
| ser_data | input | 1 | Asynchronous serial data |
| ser_load | input | 1 | Asynchronous load strobe |
| ref_div | output | 14 | Reference divide value |
| cnt_a | output | 5 | A counter value |
| cnt_b | output | 13 | B counter value |
| func_word | output | 19 | Function latch payload |
| init_word | output | 19 | Initialization latch payload |
| ref_upd | output | 1 | Reference latch update strobe |
| cnt_upd | output | 1 | Counter latch update strobe |
| func_upd | output | 1 | Function latch update strobe |
| init_upd | output | 1 | Initialization latch update strobe |

## Verification
The hardest case to reach from the ports is a serial clock edge that arrives while the load line is already high. A normal host never sends one, so the bench raises the load line and then toggles the serial clock with the data line held opposite to the word. It then loads a second time and checks that the word was not disturbed. The bench also sweeps all four control codes with walking-one and alternating payloads, and it checks that the latches nobody addressed hold their earlier values.

// File: rtl/sll_pkg.sv
package sll_pkg;
  localparam int unsigned WORD_W = 21;
  localparam int unsigned CTRL_W = 2;
  localparam int unsigned REF_W  = 14;
  localparam int unsigned A_W    = 5;
  localparam int unsigned B_W    = 13;
  localparam int unsigned FN_W   = WORD_W - CTRL_W;

  typedef enum logic [CTRL_W-1:0] {
    DST_REF  = 2'b00,
    DST_CNT  = 2'b01,
    DST_FUNC = 2'b10,
    DST_INIT = 2'b11
  } dest_e;
endpackage

// File: rtl/sll_sync_edge.sv
module sll_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/sll_shifter.sv
module sll_shifter #(
  parameter int unsigned WIDTH = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (shift_en) word <= {word[WIDTH-2:0], bit_in};
  end
endmodule

// File: rtl/sll_latch_bank.sv
module sll_latch_bank
  import sll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [REF_W-1:0]  ref_div,
  output logic [A_W-1:0]    cnt_a,
  output logic [B_W-1:0]    cnt_b,
  output logic [FN_W-1:0]   func_word,
  output logic [FN_W-1:0]   init_word,
  output logic              ref_upd,
  output logic              cnt_upd,
  output logic              func_upd,
  output logic              init_upd
);
  localparam int unsigned A_LO = CTRL_W;
  localparam int unsigned B_LO = CTRL_W + A_W;

  dest_e dst;
  logic [3:0] sel;

  assign dst = dest_e'(word[CTRL_W-1:0]);

  always_comb begin
    sel = '0;
    if (load) begin
      unique case (dst)
        DST_REF:  sel[0] = 1'b1;
        DST_CNT:  sel[1] = 1'b1;
        DST_FUNC: sel[2] = 1'b1;
        DST_INIT: begin sel[2] = 1'b1; sel[3] = 1'b1; end
        default:  sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_div   <= '0;
      cnt_a     <= '0;
      cnt_b     <= '0;
      func_word <= '0;
      init_word <= '0;
      ref_upd   <= 1'b0;
      cnt_upd   <= 1'b0;
      func_upd  <= 1'b0;
      init_upd  <= 1'b0;
    end else begin
      ref_upd  <= sel[0];
      cnt_upd  <= sel[1];
      func_upd <= sel[2];
      init_upd <= sel[3];
      if (sel[0]) ref_div <= word[CTRL_W +: REF_W];
      if (sel[1]) begin
        cnt_a <= word[A_LO +: A_W];
        cnt_b <= word[B_LO +: B_W];
      end
      if (sel[2]) func_word <= word[WORD_W-1:CTRL_W];
      if (sel[3]) init_word <= word[WORD_W-1:CTRL_W];
    end
  end
endmodule

// File: rtl/serial_latch_loader.sv
module serial_latch_loader
  import sll_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_div,
  output logic [A_W-1:0]    cnt_a,
  output logic [B_W-1:0]    cnt_b,
  output logic [FN_W-1:0]   func_word,
  output logic [FN_W-1:0]   init_word,
  output logic              ref_upd,
  output logic              cnt_upd,
  output logic              func_upd,
  output logic              init_upd
);
  logic sclk_lvl, sclk_rise;
  logic load_lvl, load_rise;
  logic data_lvl, data_rise;
  logic shift_en;
  logic [WORD_W-1:0] word;

  sll_sync_edge #(.STAGES(SYNC_STAGES)) u_sclk (
    .clk(clk), .rst(rst), .din(ser_clk), .level(sclk_lvl), .rise(sclk_rise));
  sll_sync_edge #(.STAGES(SYNC_STAGES)) u_load (
    .clk(clk), .rst(rst), .din(ser_load), .level(load_lvl), .rise(load_rise));
  sll_sync_edge #(.STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rst(rst), .din(ser_data), .level(data_lvl), .rise(data_rise));

  assign shift_en = sclk_rise & ~load_lvl;

  sll_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(data_lvl), .word(word));

  sll_latch_bank u_bank (
    .clk(clk), .rst(rst), .load(load_rise), .word(word),
    .ref_div(ref_div), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .func_word(func_word), .init_word(init_word),
    .ref_upd(ref_upd), .cnt_upd(cnt_upd), .func_upd(func_upd), .init_upd(init_upd));

  logic unused_ok;
  assign unused_ok = sclk_lvl ^ data_rise;
endmodule

// File: rtl/serial_latch_loader_chk.sv
module serial_latch_loader_chk
  import sll_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [REF_W-1:0]  ref_div,
  input logic [A_W-1:0]    cnt_a,
  input logic [B_W-1:0]    cnt_b,
  input logic [FN_W-1:0]   func_word,
  input logic [FN_W-1:0]   init_word,
  input logic              ref_upd,
  input logic              cnt_upd,
  input logic              func_upd,
  input logic              init_upd,
  input logic              load_rise
);
  // R8: a strobe never stays high for two cycles in a row
  a_r8_ref_pulse:  assert property (@(posedge clk) disable iff (rst) ref_upd  |=> !ref_upd);
  a_r8_cnt_pulse:  assert property (@(posedge clk) disable iff (rst) cnt_upd  |=> !cnt_upd);
  a_r8_func_pulse: assert property (@(posedge clk) disable iff (rst) func_upd |=> !func_upd);
  // R7: an initialization write always rewrites the function latch too
  a_r7_init_func:  assert property (@(posedge clk) disable iff (rst) init_upd |-> func_upd && func_word == init_word);
  // R8: at most one primary destination per load
  a_r8_one_dest:   assert property (@(posedge clk) disable iff (rst) $onehot0({ref_upd, cnt_upd, func_upd}));
  // R8: strobes only follow a load edge
  a_r8_from_load:  assert property (@(posedge clk) disable iff (rst)
                     (ref_upd || cnt_upd || func_upd) |-> $past(load_rise));
  // R10: unaddressed latches hold
  a_r10_ref_hold:  assert property (@(posedge clk) disable iff (rst) !ref_upd |-> $stable(ref_div));
  a_r10_cnt_hold:  assert property (@(posedge clk) disable iff (rst) !cnt_upd |-> $stable(cnt_a) && $stable(cnt_b));
  a_r10_init_hold: assert property (@(posedge clk) disable iff (rst) !init_upd |-> $stable(init_word));
endmodule

bind serial_latch_loader serial_latch_loader_chk u_chk (
  .clk(clk), .rst(rst), .ref_div(ref_div), .cnt_a(cnt_a), .cnt_b(cnt_b),
  .func_word(func_word), .init_word(init_word), .ref_upd(ref_upd),
  .cnt_upd(cnt_upd), .func_upd(func_upd), .init_upd(init_upd),
  .load_rise(load_rise));

// File: tb/test_serial_latch_loader.sv
`timescale 1ns/1ps
module test_serial_latch_loader;
  logic clk = 0;
  logic rst = 1;
  logic ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [13:0] ref_div;
  logic [4:0]  cnt_a;
  logic [12:0] cnt_b;
  logic [18:0] func_word, init_word;
  logic ref_upd, cnt_upd, func_upd, init_upd;

  int tests = 0, fails = 0;
  int ups [4];
  logic [13:0] e_ref = 0;
  logic [4:0]  e_a = 0;
  logic [12:0] e_b = 0;
  logic [18:0] e_fn = 0, e_in = 0;

  always #4 clk = ~clk;

  serial_latch_loader i_serial_latch_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .ref_div(ref_div), .cnt_a(cnt_a), .cnt_b(cnt_b), .func_word(func_word),
    .init_word(init_word), .ref_upd(ref_upd), .cnt_upd(cnt_upd),
    .func_upd(func_upd), .init_upd(init_upd));

  // strobe counters sampled at negedge
  always @(negedge clk) if (!rst) begin
    if (ref_upd)  ups[0]++;
    if (cnt_upd)  ups[1]++;
    if (func_upd) ups[2]++;
    if (init_upd) ups[3]++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_data = b; waitc(4);
    ser_clk = 1;  waitc(4);
    ser_clk = 0;  waitc(4);
  endtask

  task automatic send_word(logic [20:0] w);
    for (int i = 20; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load(logic [20:0] w, bit extra);
    for (int k = 0; k < 4; k++) ups[k] = 0;
    ser_load = 1; waitc(4);
    if (extra) begin
      for (int j = 0; j < 3; j++) begin
        ser_data = ~w[0]; waitc(2); ser_clk = 1; waitc(3); ser_clk = 0; waitc(3);
      end
    end
    ser_load = 0; waitc(6);
  endtask

  task automatic expect_update(logic [20:0] w);
    case (w[1:0])
      2'b00: e_ref = w[15:2];
      2'b01: begin e_a = w[6:2]; e_b = w[19:7]; end
      2'b10: e_fn = w[20:2];
      default: begin e_fn = w[20:2]; e_in = w[20:2]; end
    endcase
  endtask

  task automatic check_all(logic [20:0] w, string tag);
    chk({"R4 ref ", tag}, 32'(ref_div), 32'(e_ref));
    chk({"R5 A ", tag}, 32'(cnt_a), 32'(e_a));
    chk({"R5 B ", tag}, 32'(cnt_b), 32'(e_b));
    chk({"R6 func ", tag}, 32'(func_word), 32'(e_fn));
    chk({"R6 init ", tag}, 32'(init_word), 32'(e_in));
    chk({"R8 ref strobe ", tag}, 32'(ups[0]), 32'(w[1:0] == 2'b00));
    chk({"R8 cnt strobe ", tag}, 32'(ups[1]), 32'(w[1:0] == 2'b01));
    chk({"R7 func strobe ", tag}, 32'(ups[2]), 32'(w[1]));
    chk({"R7 init strobe ", tag}, 32'(ups[3]), 32'(w[1:0] == 2'b11));
  endtask

  task automatic do_word(logic [20:0] w, bit extra, string tag);
    send_word(w);
    pulse_load(w, extra);
    expect_update(w);
    check_all(w, tag);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) ups[k] = 0;
    waitc(4);
    rst = 0;
    waitc(2);
    // R1 reset state
    chk("R1 ref", 32'(ref_div), 0);
    chk("R1 A/B", 32'({cnt_a, cnt_b}), 0);
    chk("R1 func/init", 32'(func_word | init_word), 0);
    chk("R1 strobes", 32'({ref_upd, cnt_upd, func_upd, init_upd}), 0);
    // R3 sweep of codes with several payloads (R2 MSB-first ordering)
    for (int c = 0; c < 4; c++) begin
      do_word({19'h2AAAA, 2'(c)}, 0, "R3 alt");
      do_word({19'h55555, 2'(c)}, 0, "R3 alt2");
      do_word({19'h7FFFF, 2'(c)}, 0, "R2 ones");
    end
    // walking one across the payload of each code (R2, R10)
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 19; b += 3)
        do_word({19'(1 << b), 2'(c)}, 0, "R10 walk");
    // R9: edges while load high are ignored
    for (int c = 0; c < 4; c++)
      do_word({19'h3C5A1 ^ 19'(c * 4099), 2'(c)}, 1, "R9 held");
    // R9: the word survives; reload it without resending
    pulse_load({19'h3C5A1 ^ 19'(3 * 4099), 2'b11}, 1);
    check_all({19'h3C5A1 ^ 19'(3 * 4099), 2'b11}, "R9 reload");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule